// File: doc/BRIEF.md
# Chunked DMA Bus Master Arbiter

This block shares one bus among several DMA channels. Each channel sits in a slot with a fixed priority, and the lowest index has the highest priority. Software or a control block loads a channel with a start address, an end address and a fill word. The channel then writes that word to every even byte address from the start up to and including the end.

The bus is never held for a whole transfer. The block moves at most `CHUNK` words, releases the bus for at least one idle cycle, and arbitrates again. A higher-priority channel started late can therefore take over a long lower-priority transfer at the next chunk boundary. The preempted channel resumes later at the word where it stopped.

A single interrupt request line competes for the idle gaps. While any transfer is pending, the interrupt is granted at most once per gap, and the next chunk follows one cycle after the grant. When no transfer is pending, the interrupt is granted in every cycle it is requested.

Top module: `dma_chunk_arb`

## Requirements
- R1: During reset and in the first cycle after it, `wr_en_o`, `irq_gnt_o`, `busy_o` and `done_o` are all zero.
- R2: A channel loaded through the `cfg_*` port, with `cfg_ch_i` holding its binary index, writes every even address from start to end, each exactly once and in ascending order. Every one of these writes carries that channel's fill word on `wr_data_o` and its index on `wr_ch_o`, and bit i of `busy_o` is high from the cycle after the load until the cycle after its last write.
- R3: A run of back-to-back write cycles never exceeds `CHUNK` and ends only after `CHUNK` words or on the channel's last word. When no interrupt is requested, two chunks of one running transfer are separated by exactly one idle cycle.
- R4: At every chunk start, the owner is the lowest-index channel that is busy. A start presented in cycle c takes part in arbitration from cycle c+1, so its first write comes no earlier than cycle c+2.
- R5: A higher-priority channel started while a lower one runs takes over at the next chunk boundary. The preempted channel later continues from its next unwritten address and completes after the higher channel.
- R6: Bit i of `done_o` pulses for exactly one cycle per transfer, in the cycle of channel i's last write. Bit i of `busy_o` is low in the following cycle.
- R7: A start aimed at a channel whose busy bit is set is ignored: addresses, end and fill word stay unchanged, and no extra done pulse occurs.
- R8: `irq_gnt_o` is high only while `irq_req_i` is high, and never in a cycle with a write.
- R9: While any channel is busy, no two consecutive cycles carry a grant, and the cycle after a grant carries no write. With the request held high, two chunks of one transfer are separated by exactly two idle cycles.
- R10: When no channel is busy, `irq_gnt_o` follows `irq_req_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start_i | input | 1 | Load and start the channel named by `cfg_ch_i` |
| cfg_ch_i | input | CHW | Target channel index (binary) |
| cfg_saddr_i | input | AW | First byte address (even) |
| cfg_eaddr_i | input | AW | Last byte address, inclusive (even, not below start) |
| cfg_fill_i | input | DW | Word written to every address |
| irq_req_i | input | 1 | Interrupt request, level |
| irq_gnt_o | output | 1 | Interrupt grant in an idle gap |
| wr_en_o | output | 1 | Bus write in this cycle |
| wr_ch_o | output | CHW | Channel that owns the write |
| wr_addr_o | output | AW | Byte address of the write |
| wr_data_o | output | DW | Data of the write |
| busy_o | output | NCH | Bit i: channel i holds an unfinished transfer |
| done_o | output | NCH | Bit i: channel i's last word is written this cycle |

## Verification
The bench sweeps transfer lengths from 1 to 20 words on every channel. Lengths of exactly one chunk, one word past a chunk, and a single word expose an off-by-one counter, which shows up as a nine-word run or an early release. It starts a high-priority channel at each delay from 0 to 12 cycles after a long low-priority one. A design that skipped re-arbitration would let the low channel finish first, and a design that lost its place on resume would break the address chain. Restarting a busy channel with a different fill word catches a design that reloads its registers mid-transfer. A held interrupt request catches starvation of the DMA, or a grant that overlaps a write or lands twice in one gap.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;

  typedef enum logic {
    SEQ_ARB  = 1'b0,
    SEQ_XFER = 1'b1
  } seq_state_e;

  // byte address of the word that follows a
  function automatic logic [31:0] addr_after(input logic [31:0] a);
    return a + 32'd2;
  endfunction

  // index of the lowest set bit (0 when none is set)
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/dma_chan_slot.sv
`timescale 1ns/1ps
module dma_chan_slot #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] saddr_i,
  input  logic [AW-1:0] eaddr_i,
  input  logic [DW-1:0] fill_i,
  input  logic          adv_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] fill_o,
  output logic          last_o,
  output logic          done_o
);
  import dma_arb_pkg::*;

  logic [AW-1:0] cur_q, end_q;
  logic [DW-1:0] fill_q;
  logic          busy_q;
  logic [AW-1:0] cur_nxt;

  assign cur_nxt = AW'(addr_after(32'(cur_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      end_q  <= '0;
      fill_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      cur_q  <= saddr_i;
      end_q  <= eaddr_i;
      fill_q <= fill_i;
      busy_q <= 1'b1;
    end else if (adv_i && busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        cur_q  <= cur_nxt;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cur_q;
  assign fill_o = fill_q;
  assign last_o = busy_q && (cur_q == end_q);
  assign done_o = adv_i && last_o;

endmodule

// File: rtl/dma_slot_picker.sv
`timescale 1ns/1ps
module dma_slot_picker #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CHW-1:0] idx_o
);
  import dma_arb_pkg::*;

  assign any_o = |req_i;
  assign idx_o = CHW'(first_set(32'(req_i)));

endmodule

// File: rtl/dma_chunk_seq.sv
`timescale 1ns/1ps
module dma_chunk_seq #(
  parameter int NCH   = 4,
  parameter int CHUNK = 8,
  parameter int CHW   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_busy_i,
  input  logic [CHW-1:0] pick_i,
  input  logic           owner_last_i,
  input  logic           irq_req_i,
  output logic           irq_gnt_o,
  output logic           xfer_o,
  output logic [CHW-1:0] owner_o,
  output logic           chunk_end_o,
  output logic           chunk_start_o
);
  import dma_arb_pkg::*;

  localparam int CNTW = $clog2(CHUNK + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(CHUNK - 1);

  seq_state_e     state_q;
  logic [CHW-1:0] owner_q;
  logic [CNTW-1:0] cnt_q;
  logic           gap_used_q;
  logic           irq_ok;

  assign irq_ok        = (state_q == SEQ_ARB) && irq_req_i && (!gap_used_q || !any_busy_i);
  assign chunk_start_o = (state_q == SEQ_ARB) && !irq_ok && any_busy_i;
  assign chunk_end_o   = (state_q == SEQ_XFER) && (owner_last_i || (cnt_q == CNT_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_ARB;
      owner_q    <= '0;
      cnt_q      <= '0;
      gap_used_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_ARB: begin
          if (chunk_start_o) begin
            state_q    <= SEQ_XFER;
            owner_q    <= pick_i;
            cnt_q      <= '0;
            gap_used_q <= 1'b0;
          end else if (irq_ok) begin
            gap_used_q <= 1'b1;
          end
        end
        default: begin
          if (chunk_end_o) begin
            state_q <= SEQ_ARB;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign irq_gnt_o = irq_ok;
  assign xfer_o    = (state_q == SEQ_XFER);
  assign owner_o   = owner_q;

endmodule

// File: rtl/dma_chunk_arb.sv
`timescale 1ns/1ps
module dma_chunk_arb #(
  parameter int NCH   = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CHUNK = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_start_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [AW-1:0]  cfg_saddr_i,
  input  logic [AW-1:0]  cfg_eaddr_i,
  input  logic [DW-1:0]  cfg_fill_i,
  input  logic           irq_req_i,
  output logic           irq_gnt_o,
  output logic           wr_en_o,
  output logic [CHW-1:0] wr_ch_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic [NCH-1:0] busy_o,
  output logic [NCH-1:0] done_o
);

  logic [NCH-1:0] busy_vec;
  logic [NCH-1:0] last_vec;
  logic [AW-1:0]  slot_addr [NCH];
  logic [DW-1:0]  slot_fill [NCH];

  // named internal events, used by the bound checker
  logic           seq_xfer;
  logic [CHW-1:0] seq_owner;
  logic           seq_chunk_end;
  logic           seq_chunk_start;
  logic           pick_any;
  logic [CHW-1:0] pick_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic load_g, adv_g;
    assign load_g = cfg_start_i && (cfg_ch_i == CHW'(g));
    assign adv_g  = seq_xfer && (seq_owner == CHW'(g));

    dma_chan_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_g),
      .saddr_i (cfg_saddr_i),
      .eaddr_i (cfg_eaddr_i),
      .fill_i  (cfg_fill_i),
      .adv_i   (adv_g),
      .busy_o  (busy_vec[g]),
      .addr_o  (slot_addr[g]),
      .fill_o  (slot_fill[g]),
      .last_o  (last_vec[g]),
      .done_o  (done_o[g])
    );
  end

  dma_slot_picker #(.NCH(NCH), .CHW(CHW)) u_pick (
    .req_i (busy_vec),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  dma_chunk_seq #(.NCH(NCH), .CHUNK(CHUNK), .CHW(CHW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .any_busy_i    (pick_any),
    .pick_i        (pick_idx),
    .owner_last_i  (last_vec[seq_owner]),
    .irq_req_i     (irq_req_i),
    .irq_gnt_o     (irq_gnt_o),
    .xfer_o        (seq_xfer),
    .owner_o       (seq_owner),
    .chunk_end_o   (seq_chunk_end),
    .chunk_start_o (seq_chunk_start)
  );

  assign wr_en_o   = seq_xfer;
  assign wr_ch_o   = seq_owner;
  assign wr_addr_o = slot_addr[seq_owner];
  assign wr_data_o = slot_fill[seq_owner];
  assign busy_o    = busy_vec;

endmodule

// File: rtl/dma_chunk_arb_chk.sv
`timescale 1ns/1ps
module dma_chunk_arb_chk #(
  parameter int NCH   = 4,
  parameter int AW    = 16,
  parameter int CHUNK = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_req_i,
  input logic           irq_gnt_o,
  input logic           wr_en_o,
  input logic [CHW-1:0] wr_ch_o,
  input logic [AW-1:0]  wr_addr_o,
  input logic [NCH-1:0] busy_o,
  input logic [NCH-1:0] done_o,
  input logic           seq_chunk_end,
  input logic           seq_chunk_start
);

  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (wr_en_o) run_q <= run_q + 32'd1;
    else              run_q <= '0;
  end

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && $past(wr_en_o) |-> (wr_ch_o == $past(wr_ch_o)) && (wr_addr_o == $past(wr_addr_o) + AW'(2))); // R2
  AST_WRITE_OWNER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o[wr_ch_o]); // R2
  AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> run_q < 32'(CHUNK)); // R3
  AST_CHUNK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_chunk_end |=> !wr_en_o); // R3
  AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_chunk_start |-> (busy_o != '0) && !irq_gnt_o); // R4
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o)); // R6
  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |-> wr_en_o && done_o[wr_ch_o]); // R6
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |=> (busy_o & $past(done_o)) == '0); // R6
  AST_IRQ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gnt_o |-> !wr_en_o && irq_req_i); // R8
  AST_IRQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gnt_o |=> !wr_en_o); // R9
  AST_IRQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gnt_o && (busy_o != '0) |=> !irq_gnt_o); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_i && (busy_o == '0) |-> irq_gnt_o); // R10

endmodule

bind dma_chunk_arb dma_chunk_arb_chk #(.NCH(NCH), .AW(AW), .CHUNK(CHUNK)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .irq_req_i       (irq_req_i),
  .irq_gnt_o       (irq_gnt_o),
  .wr_en_o         (wr_en_o),
  .wr_ch_o         (wr_ch_o),
  .wr_addr_o       (wr_addr_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .seq_chunk_end   (seq_chunk_end),
  .seq_chunk_start (seq_chunk_start)
);

// File: tb/test_dma_chunk_arb.sv
`timescale 1ns/1ps
module test_dma_chunk_arb;
  localparam int NCH = 4, AW = 16, DW = 16, CHUNK = 8, CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_start = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [AW-1:0]  cfg_saddr = '0, cfg_eaddr = '0;
  logic [DW-1:0]  cfg_fill = '0;
  logic           irq_req = 1'b0;
  logic           irq_gnt, wr_en;
  logic [CHW-1:0] wr_ch;
  logic [AW-1:0]  wr_addr;
  logic [DW-1:0]  wr_data;
  logic [NCH-1:0] busy, done;

  dma_chunk_arb #(.NCH(NCH), .AW(AW), .DW(DW), .CHUNK(CHUNK)) i_dma_chunk_arb (
    .clk(clk), .rst_n(rst_n), .cfg_start_i(cfg_start), .cfg_ch_i(cfg_ch),
    .cfg_saddr_i(cfg_saddr), .cfg_eaddr_i(cfg_eaddr), .cfg_fill_i(cfg_fill),
    .irq_req_i(irq_req), .irq_gnt_o(irq_gnt), .wr_en_o(wr_en), .wr_ch_o(wr_ch),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy), .done_o(done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model
  bit          m_busy [NCH];
  logic [AW-1:0] m_next [NCH], m_end [NCH];
  logic [DW-1:0] m_fill [NCH];
  int          m_start [NCH], m_done [NCH], m_words [NCH], m_done_cyc [NCH];
  bit          p_load [NCH];
  logic [AW-1:0] p_s [NCH], p_e [NCH];
  logic [DW-1:0] p_f [NCH];
  bit prev_wr = 0, prev_gnt = 0, prev_last = 0, saw_chunk = 0, got_gnt = 0;
  int run = 0, idle = 0, gap_mode = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit any_busy();
    for (int i = 0; i < NCH; i++) if (m_busy[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_o;
      bit exp_d;
      for (int i = 0; i < NCH; i++)
        chk(busy[i] == m_busy[i], "R6", $sformatf("busy[%0d]", i), busy[i], m_busy[i]);
      if (irq_gnt) begin
        chk(!wr_en, "R8", "write during grant", wr_en, 0);
        chk(irq_req, "R8", "grant without request", irq_req, 1);
        got_gnt = 1;
      end
      if (prev_gnt) chk(!wr_en, "R9", "write right after grant", wr_en, 0);
      if (irq_gnt && prev_gnt) chk(!any_busy(), "R9", "two grants in one gap", 1, 0);
      if (irq_req && !any_busy()) chk(irq_gnt, "R10", "idle grant", irq_gnt, 1);
      for (int i = 0; i < NCH; i++) begin
        exp_d = wr_en && (int'(wr_ch) == i) && m_busy[i] && (wr_addr == m_end[i]);
        chk(done[i] == exp_d, "R6", $sformatf("done[%0d]", i), done[i], exp_d);
      end
      if (wr_en) begin
        chk(m_busy[wr_ch], "R2", "write by idle channel", 0, 1);
        chk(wr_addr == m_next[wr_ch], "R5", "write address", wr_addr, m_next[wr_ch]);
        chk(wr_data == m_fill[wr_ch], "R2", "write data", wr_data, m_fill[wr_ch]);
        if (!prev_wr) begin
          exp_o = -1;
          for (int i = NCH - 1; i >= 0; i--)
            if (m_busy[i] && m_start[i] <= cyc - 2) exp_o = i;
          chk(int'(wr_ch) == exp_o, "R4", "chunk owner", wr_ch, exp_o);
          if (gap_mode != 0 && saw_chunk && !prev_last)
            chk(idle == gap_mode, (gap_mode == 1) ? "R3" : "R9", "gap length", idle, gap_mode);
          saw_chunk = 1;
          idle = 0;
        end
        run++;
        chk(run <= CHUNK, "R3", "run length", run, CHUNK);
        m_words[wr_ch]++;
        if (wr_addr == m_end[wr_ch]) begin
          m_busy[wr_ch] = 0;
          m_done[wr_ch]++;
          m_done_cyc[wr_ch] = cyc;
          prev_last = 1;
        end else begin
          m_next[wr_ch] = m_next[wr_ch] + AW'(2);
          prev_last = 0;
        end
      end else begin
        if (prev_wr) chk(run == CHUNK || prev_last, "R3", "early release", run, CHUNK);
        run = 0;
        idle++;
      end
      prev_wr = wr_en;
      prev_gnt = irq_gnt;
      for (int i = 0; i < NCH; i++) begin
        if (p_load[i]) begin
          m_busy[i] = 1; m_next[i] = p_s[i]; m_end[i] = p_e[i]; m_fill[i] = p_f[i];
          m_start[i] = cyc; p_load[i] = 0;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic start_ch(input int ch, input int s, input int n, input int f);
    tick();
    cfg_start = 1; cfg_ch = CHW'(ch);
    cfg_saddr = AW'(s); cfg_eaddr = AW'(s + 2 * (n - 1)); cfg_fill = DW'(f);
    if (!m_busy[ch] && !p_load[ch]) begin
      p_load[ch] = 1; p_s[ch] = AW'(s); p_e[ch] = AW'(s + 2 * (n - 1)); p_f[ch] = DW'(f);
    end
    tick();
    cfg_start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((any_busy() || p_load[0] || p_load[1] || p_load[2] || p_load[3]) && guard < 2000);
    chk(guard < 2000, "R2", "transfer did not finish", guard, 2000);
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w0, d0;
    for (int i = 0; i < NCH; i++) begin
      m_busy[i] = 0; m_start[i] = 0; m_done[i] = 0; m_words[i] = 0; p_load[i] = 0;
      m_next[i] = '0; m_end[i] = '0; m_fill[i] = '0; m_done_cyc[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!wr_en && !irq_gnt && busy == '0 && done == '0, "R1", "outputs in reset", wr_en, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!wr_en && busy == '0 && done == '0, "R1", "outputs after reset", busy, 0);

    // R2, R3, R6: every channel alone, lengths 1..20
    gap_mode = 1;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 1; n <= 20; n++) begin
        w0 = m_words[ch]; d0 = m_done[ch]; saw_chunk = 0;
        start_ch(ch, 'h0100 + ch * 'h1000, n, ch * 256 + n);
        wait_idle();
        chk(m_words[ch] - w0 == n, "R2", "word count", m_words[ch] - w0, n);
        chk(m_done[ch] - d0 == 1, "R6", "done pulses", m_done[ch] - d0, 1);
      end
    end

    // R4: all channels queued, lowest index first at each boundary
    gap_mode = 0;
    for (int ch = NCH - 1; ch >= 0; ch--) start_ch(ch, 'h4000 + ch * 'h100, 20, 'hA0 + ch);
    wait_idle();
    for (int ch = 1; ch < NCH; ch++)
      chk(m_done_cyc[ch] > m_done_cyc[ch - 1], "R4", "completion order", m_done_cyc[ch], m_done_cyc[ch - 1]);

    // R5: preemption at each start delay, same memory range
    for (int d = 0; d <= 12; d++) begin
      w0 = m_words[3];
      start_ch(3, 'h2000, 30, 'hAAAA);
      repeat (d) tick();
      start_ch(0, 'h2000, 10, 'h5555);
      wait_idle();
      chk(m_done_cyc[3] > m_done_cyc[0], "R5", "preempted channel finishes later", m_done_cyc[3], m_done_cyc[0]);
      chk(m_words[3] - w0 == 30, "R5", "preempted channel word count", m_words[3] - w0, 30);
    end

    // R7: restart of a busy channel is ignored
    w0 = m_words[1]; d0 = m_done[1];
    start_ch(1, 'h3000, 30, 'h1111);
    repeat (3) tick();
    start_ch(1, 'h3800, 5, 'h2222);
    wait_idle();
    chk(m_words[1] - w0 == 30, "R7", "word count after ignored start", m_words[1] - w0, 30);
    chk(m_done[1] - d0 == 1, "R7", "done pulses after ignored start", m_done[1] - d0, 1);

    // R8: short interrupt requests during a transfer
    for (int off = 0; off <= 10; off++) begin
      start_ch(2, 'h5000, 24, 'h0C00 + off);
      repeat (off) tick();
      got_gnt = 0;
      irq_req = 1;
      while (!got_gnt) @(negedge clk);
      tick();
      irq_req = 0;
      chk(got_gnt, "R8", "interrupt granted", got_gnt, 1);
      wait_idle();
    end

    // R9, R10: request held across a transfer
    irq_req = 1;
    repeat (4) tick();
    gap_mode = 2; saw_chunk = 0;
    w0 = m_words[0];
    start_ch(0, 'h6000, 24, 'h7777);
    wait_idle();
    chk(m_words[0] - w0 == 24, "R9", "transfer under held request", m_words[0] - w0, 24);
    repeat (3) tick();
    irq_req = 0;
    gap_mode = 0;
    repeat (3) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule